// File: doc/BRIEF.md
# Two-Stage Memory Attribute Remapper

This block turns the attribute bits of a page-table entry into the memory attributes the rest of the memory system acts on. These attributes are a memory type (Strongly Ordered, Device or Normal), a shareable flag, an inner cacheability and an outer cacheability. The three bits TEX[0], C and B form a 3-bit index `n = {tex0, c, b}`. When remapping is on, this index selects a programmable entry in two configuration registers.

Resolution happens in two dependent stages. Stage one reads the type register and gives the memory type and the shareable flag. Stage two reads the cacheability register and gives inner and outer cacheability, but only for regions that stage one resolved as Normal. Device and Strongly Ordered results are forced to non-cacheable. When the global enable is low, neither register is used. A fixed decode of the index supplies type and cacheability, and the page-table shareable bit passes straight through. The security (non-secure) bit is never touched by either path.

Software reaches the registers through a 1-bit select, a write strobe, write data and combinational read data. A small two-state controller (states `ST_IDLE` and `ST_STALE`) raises a one-cycle stale pulse after every write. This tells the surrounding system that cached translations no longer hold. The controller moves `ST_IDLE -> ST_STALE` on a write. It stays in `ST_STALE` on a further write and returns `ST_STALE -> ST_IDLE` when no write occurs.

Top module: `attr_remap`

## Requirements
- R1: `cfg_sel` = 0 addresses the type register and `cfg_sel` = 1 addresses the cacheability register. A write with `cfg_we` high lands at the clock edge and is visible on `cfg_rdata` from the next cycle. The type register implements bits [23:0] only, and bits [31:24] read as zero. Writing one register leaves the other unchanged.
- R2: After reset, the type register reads 0x00008AA4 and the cacheability register reads 0x44E044E0.
- R3: With `remap_en` low, type and cacheability follow this fixed decode of n: 0 = SO; 1 = Device; 2 = Normal WT; 3 = Normal WB-no-alloc; 4 = Normal NC; 5 = Normal WB-WA; 6 = SO; 7 = Normal WB-WA. Inner and outer are equal, and `out_shared` equals `pt_s`.
- R4: With `remap_en` high, `out_type` is type-register bits [2n+1:2n]. The encoding is 00 SO, 01 Device, 10 Normal, and the reserved code 11 is output as 00 (SO).
- R5: With `remap_en` high, `out_shared` equals type-register bit [16+n], whatever the value of `pt_s`.
- R6: With `remap_en` high and a Normal type, `out_inner` is cacheability-register bits [2n+1:2n] and `out_outer` is bits [16+2n+1:16+2n]. The encoding is 00 NC, 01 WB-WA, 10 WT, 11 WB-no-alloc.
- R7: Whenever `out_type` is not Normal (10), `out_inner` and `out_outer` are 00.
- R8: `out_ns` equals `pt_ns` in every mode.
- R9: `cfg_stale` is high in the cycle after every cycle in which `cfg_we` is high, and low otherwise.
- R10: With the reset register values, enabling remap gives the same type and cacheability as the bypass decode for every n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Register select: 0 type, 1 cacheability |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of selected register |
| remap_en | input | 1 | Global remap enable |
| pt_tex0 | input | 1 | Page-table TEX[0] |
| pt_c | input | 1 | Page-table C bit |
| pt_b | input | 1 | Page-table B bit |
| pt_s | input | 1 | Page-table shareable bit |
| pt_ns | input | 1 | Page-table non-secure bit |
| out_type | output | 2 | Resolved memory type |
| out_shared | output | 1 | Resolved shareable flag |
| out_inner | output | 2 | Resolved inner cacheability |
| out_outer | output | 2 | Resolved outer cacheability |
| out_ns | output | 1 | Forwarded non-secure bit |
| cfg_stale | output | 1 | One-cycle pulse after a write |

## Verification
The bench goes after the reserved type code 11, which a careless design would pass out as-is instead of folding it to Strongly Ordered. It also covers Device and Strongly Ordered entries whose cacheability fields are nonzero; a design that skipped the stage dependency would leak those cache codes. In bypass it toggles `pt_s` against a type register whose shareable bits disagree, so a design that read the register there gets the wrong shareable flag. Back-to-back writes, writes to the upper type-register bits, and index 7 (top field positions) catch a stretched or dropped stale pulse, phantom storage and off-by-one field slicing.

// File: rtl/attr_remap_pkg.sv
package attr_remap_pkg;

    localparam int IDX_W   = 3;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int FIELD_W = 2;
    localparam int SHR_OFS = FIELD_W * ENTRIES;
    localparam int PRIM_W  = SHR_OFS + ENTRIES;
    localparam int NORM_W  = 2 * FIELD_W * ENTRIES;
    localparam int OUTER_OFS = FIELD_W * ENTRIES;
    localparam int CFG_W   = 32;

    typedef enum logic [1:0] {
        MT_STRONG = 2'b00,
        MT_DEVICE = 2'b01,
        MT_NORMAL = 2'b10,
        MT_RSVD   = 2'b11
    } mem_type_e;

    typedef enum logic [1:0] {
        CA_NONE = 2'b00,
        CA_WBWA = 2'b01,
        CA_WT   = 2'b10,
        CA_WBNA = 2'b11
    } cache_e;

    function automatic mem_type_e bypass_type(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0, 3'd6: return MT_STRONG;
            3'd1:       return MT_DEVICE;
            default:    return MT_NORMAL;
        endcase
    endfunction

    function automatic cache_e bypass_cache(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd2:       return CA_WT;
            3'd3:       return CA_WBNA;
            3'd5, 3'd7: return CA_WBWA;
            default:    return CA_NONE;
        endcase
    endfunction

    function automatic logic [PRIM_W-1:0] prim_reset_value();
        logic [PRIM_W-1:0] r;
        r = '0;
        for (int n = 0; n < ENTRIES; n++) begin
            r[FIELD_W*n +: FIELD_W] = bypass_type(IDX_W'(n));
        end
        return r;
    endfunction

    function automatic logic [NORM_W-1:0] norm_reset_value();
        logic [NORM_W-1:0] r;
        r = '0;
        for (int n = 0; n < ENTRIES; n++) begin
            r[FIELD_W*n +: FIELD_W]             = bypass_cache(IDX_W'(n));
            r[OUTER_OFS + FIELD_W*n +: FIELD_W] = bypass_cache(IDX_W'(n));
        end
        return r;
    endfunction

endpackage

// File: rtl/attr_remap_regs.sv
module attr_remap_regs
    import attr_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic [PRIM_W-1:0] prim_q,
    output logic [NORM_W-1:0] norm_q,
    output logic              cfg_stale
);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_STALE = 1'b1
    } stale_state_e;

    stale_state_e state_q, state_d;

    // configuration storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prim_q <= prim_reset_value();
            norm_q <= norm_reset_value();
        end else if (cfg_we) begin
            if (cfg_sel) begin
                norm_q <= cfg_wdata[NORM_W-1:0];
            end else begin
                prim_q <= cfg_wdata[PRIM_W-1:0];
            end
        end
    end

    // readback: unimplemented bits of the type register are zero
    always_comb begin
        cfg_rdata = '0;
        if (cfg_sel) begin
            cfg_rdata[NORM_W-1:0] = norm_q;
        end else begin
            cfg_rdata[PRIM_W-1:0] = prim_q;
        end
    end

    // next-state logic of the stale controller
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cfg_we) state_d = ST_STALE;
            ST_STALE: if (!cfg_we) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs of the stale controller
    always_comb begin
        unique case (state_q)
            ST_IDLE:  cfg_stale = 1'b0;
            ST_STALE: cfg_stale = 1'b1;
        endcase
    end

endmodule

// File: rtl/attr_remap_type_stage.sv
module attr_remap_type_stage
    import attr_remap_pkg::*;
(
    input  logic              remap_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic              pt_s,
    input  logic [PRIM_W-1:0] prim_q,
    output mem_type_e         res_type,
    output logic              res_shared
);

    mem_type_e raw_type;

    always_comb begin
        raw_type = mem_type_e'(prim_q[FIELD_W*idx +: FIELD_W]);
        if (remap_en) begin
            unique case (raw_type)
                MT_STRONG, MT_RSVD: res_type = MT_STRONG;
                MT_DEVICE:          res_type = MT_DEVICE;
                MT_NORMAL:          res_type = MT_NORMAL;
            endcase
            res_shared = prim_q[SHR_OFS + idx];
        end else begin
            res_type   = bypass_type(idx);
            res_shared = pt_s;
        end
    end

endmodule

// File: rtl/attr_remap_cache_stage.sv
module attr_remap_cache_stage
    import attr_remap_pkg::*;
(
    input  logic              remap_en,
    input  logic [IDX_W-1:0]  idx,
    input  mem_type_e         res_type,
    input  logic [NORM_W-1:0] norm_q,
    output cache_e            res_inner,
    output cache_e            res_outer
);

    always_comb begin
        res_inner = CA_NONE;
        res_outer = CA_NONE;
        if (res_type == MT_NORMAL) begin
            if (remap_en) begin
                res_inner = cache_e'(norm_q[FIELD_W*idx +: FIELD_W]);
                res_outer = cache_e'(norm_q[OUTER_OFS + FIELD_W*idx +: FIELD_W]);
            end else begin
                res_inner = bypass_cache(idx);
                res_outer = bypass_cache(idx);
            end
        end
    end

endmodule

// File: rtl/attr_remap.sv
module attr_remap
    import attr_remap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        remap_en,
    input  logic        pt_tex0,
    input  logic        pt_c,
    input  logic        pt_b,
    input  logic        pt_s,
    input  logic        pt_ns,
    output logic [1:0]  out_type,
    output logic        out_shared,
    output logic [1:0]  out_inner,
    output logic [1:0]  out_outer,
    output logic        out_ns,
    output logic        cfg_stale
);

    logic [PRIM_W-1:0] prim_q;
    logic [NORM_W-1:0] norm_q;
    logic [IDX_W-1:0]  idx;
    mem_type_e         res_type;
    cache_e            res_inner, res_outer;

    assign idx = {pt_tex0, pt_c, pt_b};

    attr_remap_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .prim_q    (prim_q),
        .norm_q    (norm_q),
        .cfg_stale (cfg_stale)
    );

    attr_remap_type_stage u_type (
        .remap_en   (remap_en),
        .idx        (idx),
        .pt_s       (pt_s),
        .prim_q     (prim_q),
        .res_type   (res_type),
        .res_shared (out_shared)
    );

    attr_remap_cache_stage u_cache (
        .remap_en  (remap_en),
        .idx       (idx),
        .res_type  (res_type),
        .norm_q    (norm_q),
        .res_inner (res_inner),
        .res_outer (res_outer)
    );

    assign out_type  = res_type;
    assign out_inner = res_inner;
    assign out_outer = res_outer;
    assign out_ns    = pt_ns;

endmodule

// File: rtl/attr_remap_chk.sv
module attr_remap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_sel,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        remap_en,
    input logic        pt_s,
    input logic        pt_ns,
    input logic [1:0]  out_type,
    input logic        out_shared,
    input logic [1:0]  out_inner,
    input logic [1:0]  out_outer,
    input logic        out_ns,
    input logic        cfg_stale
);

    // R8
    ns_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ns == pt_ns);

    // R7
    nonnormal_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_type != 2'b10) |-> (out_inner == 2'b00 && out_outer == 2'b00));

    // R4
    no_reserved_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_type != 2'b11);

    // R3
    bypass_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_en |-> (out_shared == pt_s));

    // R9
    stale_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_stale);

    // R9
    stale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> !cfg_stale);

    // R1
    write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ((cfg_sel != $past(cfg_sel)) ||
                    (cfg_rdata == ($past(cfg_sel) ? $past(cfg_wdata)
                                                  : ($past(cfg_wdata) & 32'h00FF_FFFF)))));

endmodule

bind attr_remap attr_remap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_sel    (cfg_sel),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .remap_en   (remap_en),
    .pt_s       (pt_s),
    .pt_ns      (pt_ns),
    .out_type   (out_type),
    .out_shared (out_shared),
    .out_inner  (out_inner),
    .out_outer  (out_outer),
    .out_ns     (out_ns),
    .cfg_stale  (cfg_stale)
);

// File: tb/attr_remap_bench.sv
module attr_remap_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        remap_en = 1'b0;
    logic        pt_tex0 = 1'b0, pt_c = 1'b0, pt_b = 1'b0, pt_s = 1'b0, pt_ns = 1'b0;
    logic [1:0]  out_type, out_inner, out_outer;
    logic        out_shared, out_ns, cfg_stale;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_prim, m_norm;
    logic        prev_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    attr_remap u_attr_remap (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .remap_en(remap_en),
        .pt_tex0(pt_tex0), .pt_c(pt_c), .pt_b(pt_b), .pt_s(pt_s), .pt_ns(pt_ns),
        .out_type(out_type), .out_shared(out_shared), .out_inner(out_inner),
        .out_outer(out_outer), .out_ns(out_ns), .cfg_stale(cfg_stale)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] byp_type(input int n);
        if (n == 0 || n == 6) return 2'b00;
        if (n == 1) return 2'b01;
        return 2'b10;
    endfunction

    function automatic logic [1:0] byp_cache(input int n);
        case (n)
            2: return 2'b10;
            3: return 2'b11;
            5, 7: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    // check all lookup outputs against bench model for current inputs
    task automatic check_lookup();
        int n;
        logic [1:0] et, ei, eo;
        logic es;
        n = {pt_tex0, pt_c, pt_b};
        if (remap_en) begin
            et = m_prim[2*n +: 2];
            if (et == 2'b11) et = 2'b00;
            es = m_prim[16 + n];
            ei = m_norm[2*n +: 2];
            eo = m_norm[16 + 2*n +: 2];
        end else begin
            et = byp_type(n);
            es = pt_s;
            ei = byp_cache(n);
            eo = byp_cache(n);
        end
        if (et != 2'b10) begin ei = 2'b00; eo = 2'b00; end
        check(remap_en ? "R4" : "R3", "type", {30'd0, out_type}, {30'd0, et});
        check(remap_en ? "R5" : "R3", "shared", {31'd0, out_shared}, {31'd0, es});
        check(et == 2'b10 ? "R6" : "R7", "inner", {30'd0, out_inner}, {30'd0, ei});
        check(et == 2'b10 ? "R6" : "R7", "outer", {30'd0, out_outer}, {30'd0, eo});
        check("R8", "ns", {31'd0, out_ns}, {31'd0, pt_ns});
    endtask

    // one cycle: drive at negedge, check mid-low phase, then commit at posedge
    task automatic step(input logic we, input logic sel, input logic [31:0] wd,
                        input logic en, input logic [2:0] n, input logic s, input logic ns);
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; remap_en = en;
        {pt_tex0, pt_c, pt_b} = n; pt_s = s; pt_ns = ns;
        #1;
        check("R9", "stale", {31'd0, cfg_stale}, {31'd0, prev_we});
        check("R1", "rdata", cfg_rdata, sel ? m_norm : m_prim);
        check_lookup();
        @(posedge clk);
        #0;
        prev_we = we;
        if (we) begin
            if (sel) m_norm = wd;
            else     m_prim = wd & 32'h00FF_FFFF;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_prim = 32'h0000_8AA4;
        m_norm = 32'h44E0_44E0;
        prev_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 reset values, read directly
        @(negedge clk); #1;
        cfg_sel = 1'b0; #1;
        check("R2", "prim reset", cfg_rdata, 32'h0000_8AA4);
        cfg_sel = 1'b1; #1;
        check("R2", "norm reset", cfg_rdata, 32'h44E0_44E0);
        check("R9", "stale after reset", {31'd0, cfg_stale}, 32'd0);

        // R10 identity: remap on vs bypass, every index
        for (int n = 0; n < 8; n++) begin
            step(1'b0, 1'b0, 32'd0, 1'b1, n[2:0], 1'b0, n[0]);
            check("R10", "type identity", {30'd0, out_type}, {30'd0, byp_type(n)});
            check("R10", "inner identity", {30'd0, out_inner}, {30'd0, byp_cache(n)});
            step(1'b0, 1'b1, 32'd0, 1'b0, n[2:0], 1'b1, ~n[0]);
        end

        // R1 upper type-register bits read as zero; other register untouched
        step(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 3'd7, 1'b0, 1'b0);
        step(1'b0, 1'b0, 32'd0, 1'b1, 3'd7, 1'b0, 1'b1);
        check("R1", "upper zero", cfg_rdata, 32'h00FF_FFFF);
        step(1'b0, 1'b1, 32'd0, 1'b1, 3'd7, 1'b0, 1'b1);
        check("R1", "other reg kept", cfg_rdata, 32'h44E0_44E0);

        // R4 reserved code 11 everywhere -> SO, R7 cache forced off
        step(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 3'd3, 1'b1, 1'b0);
        for (int n = 0; n < 8; n++) begin
            step(1'b0, 1'b0, 32'd0, 1'b1, n[2:0], 1'b0, 1'b0);
            check("R4", "reserved->SO", {30'd0, out_type}, 32'd0);
        end

        // R7 Device entries with nonzero cache fields
        step(1'b1, 1'b0, 32'h0055_5555, 1'b1, 3'd0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 32'd0, 1'b1, 3'd5, 1'b0, 1'b0);
        check("R7", "device inner", {30'd0, out_inner}, 32'd0);

        // R3 bypass: shareable from pt_s while register disagrees
        step(1'b0, 1'b0, 32'd0, 1'b0, 3'd4, 1'b0, 1'b1);
        check("R3", "bypass shared", {31'd0, out_shared}, 32'd0);

        // R9 back-to-back writes then idle
        step(1'b1, 1'b0, 32'h00AA_AAAA, 1'b1, 3'd2, 1'b0, 1'b0);
        step(1'b1, 1'b1, 32'h1B2D_C6E4, 1'b1, 3'd2, 1'b0, 1'b0);
        step(1'b0, 1'b1, 32'd0, 1'b1, 3'd6, 1'b1, 1'b0);
        step(1'b0, 1'b0, 32'd0, 1'b1, 3'd7, 1'b1, 1'b0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[2:0] == 3'd0, r[3], $urandom(), r[4] | r[5], r[8:6], r[9], r[10]);
        end

        @(negedge clk); #1;
        check("R9", "stale final", {31'd0, cfg_stale}, {31'd0, prev_we});
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule